// File: doc/BRIEF.md
# Console CPU Bus Decoder

This block sits between an 8-bit processor's 16-bit address bus and the devices around it. On every valid bus cycle it classifies the address into one region and raises one select. The regions are the 2 KB work RAM, the eight graphics registers, the sound and I/O register window, the cartridge space and a small diagnostic window. With each select it passes on the mirrored local offset, so that the RAM and graphics register files stay small even though they fill much larger address windows.

It also owns the controller side of the I/O window. A write to the strobe address stores the low data bits in a small register that drives three output pins. A read of either controller port pulses that port's active-low enable. A test input reconfigures the top of the I/O window. In test mode, three addresses above the sound window become diagnostic registers. Reads of the two controller ports then report open bus instead of enabling a controller, so the system's data mux returns the last byte it saw on the data bus.

Top module: `cpu_bus_decoder`

## Requirements
- R1: During a valid cycle, an address in $0000-$1FFF raises `ram_sel`, and `ram_ofs` equals addr[10:0], so the 2 KB RAM repeats four times.
- R2: During a valid cycle, an address in $2000-$3FFF raises `gfx_sel`, and `gfx_ofs` equals addr[2:0], so the eight registers repeat every eight bytes.
- R3: During a valid cycle, an address in $4000-$4017 raises `snd_sel`, except for the open-bus reads described in R8.
- R4: During a valid cycle, an address in $4018-$FFFF raises `cart_sel` when `test_mode` is 0. When `test_mode` is 1, only $401B-$FFFF raise it.
- R5: At most one of `ram_sel`, `gfx_sel`, `snd_sel`, `cart_sel`, `diag_sel` and `open_bus` is 1 at any time, and all of them are 0 when `bus_valid` is 0.
- R6: `out_pins` is 000 after reset. A valid write (rw=0) to $4016 loads `bus_wdata[2:0]` into `out_pins` at the next rising clock edge, with bit 0 as the strobe. No other cycle changes `out_pins`, and writes in test mode load it as well.
- R7: When `test_mode` is 0, a valid read (rw=1) of $4016 drives `pad_en_n[0]` low and a valid read of $4017 drives `pad_en_n[1]` low, in the same cycle. Both are 1 otherwise.
- R8: When `test_mode` is 1, a valid access to $4018-$401A raises `diag_sel` with `diag_ofs` = addr[1:0] (0, 1, 2). A valid read of $4016 or $4017 raises `open_bus` and leaves both bits of `pad_en_n` at 1.
- R9: `open_bus` is 0 in every case other than the test-mode controller reads of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Address and rw are valid this cycle |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | CPU address |
| bus_wdata | input | OUT_W | Low data-bus bits, used by strobe writes |
| test_mode | input | 1 | Test input: diagnostic window, controller reads open bus |
| ram_sel | output | 1 | Work RAM select |
| ram_ofs | output | RAM_AW | RAM offset (mirrored) |
| gfx_sel | output | 1 | Graphics register select |
| gfx_ofs | output | GFX_AW | Graphics register index (mirrored) |
| snd_sel | output | 1 | Sound and I/O window select |
| cart_sel | output | 1 | Cartridge space select |
| diag_sel | output | 1 | Diagnostic register select |
| diag_ofs | output | 2 | Diagnostic register index |
| open_bus | output | 1 | Read has no driver; return last data-bus byte |
| out_pins | output | OUT_W | Controller output latch pins |
| pad_en_n | output | 2 | Active-low controller read enables |

## Verification
The bench builds the decoder with its default parameters: an 11-bit RAM offset, a 3-bit graphics index, three latch pins and the test-pin logic present. With these values every mirror boundary ($07FF/$0800, $1FFF/$2000, $2007/$2008, $3FFF/$4000), both edges of the diagnostic window and the strobe latch can be reached. Directed sweeps of these edges in both rw directions and both test-mode settings run first, then a long random run. A behavioural model in the bench checks every select, offset, enable and latch pin on each cycle.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
   localparam int ADDR_W = 16;

   localparam logic [ADDR_W-1:0] IO_BASE   = 16'h4000;
   localparam logic [ADDR_W-1:0] PAD_BASE  = 16'h4016;
   localparam logic [ADDR_W-1:0] CART_BASE = 16'h4018;
   localparam logic [ADDR_W-1:0] DIAG_LAST = 16'h401A;
   localparam int                PAD_CNT   = 2;

   typedef enum logic [2:0] {
      RG_NONE = 3'd0,
      RG_RAM  = 3'd1,
      RG_GFX  = 3'd2,
      RG_SND  = 3'd3,
      RG_CART = 3'd4,
      RG_DIAG = 3'd5,
      RG_OPEN = 3'd6
   } region_e;
endpackage

// File: rtl/cbd_region_decode.sv
module cbd_region_decode
   import cbd_pkg::*;
(
   input  logic              valid,
   input  logic              rw,
   input  logic [ADDR_W-1:0] addr,
   input  logic              test_eff,
   output region_e           region
);
   logic is_pad;
   assign is_pad = (addr == PAD_BASE) || (addr == PAD_BASE + 16'd1);

   always_comb begin
      region = RG_NONE;
      if (valid) begin
         unique case (addr[15:13])
            3'b000:  region = RG_RAM;
            3'b001:  region = RG_GFX;
            default: begin
               if (addr < CART_BASE) begin
                  if (test_eff && rw && is_pad) region = RG_OPEN;
                  else                          region = RG_SND;
               end else if (test_eff && addr <= DIAG_LAST) begin
                  region = RG_DIAG;
               end else begin
                  region = RG_CART;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cbd_out_latch.sv
module cbd_out_latch #(
   parameter int OUT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [OUT_W-1:0] d,
   output logic [OUT_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> q == $past(d)); // R6
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q)); // R6
endmodule

// File: rtl/cbd_pad_enable.sv
module cbd_pad_enable
   import cbd_pkg::*;
#(
   parameter int PADS = PAD_CNT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              rw,
   input  logic              test_eff,
   input  logic [ADDR_W-1:0] addr,
   output logic [PADS-1:0]   en_n
);
   logic rd_ok;
   assign rd_ok = valid && rw && !test_eff;

   for (genvar i = 0; i < PADS; i++) begin : g_pad
      localparam logic [ADDR_W-1:0] PAD_ADDR = PAD_BASE + ADDR_W'(i);
      assign en_n[i] = !(rd_ok && addr == PAD_ADDR);
   end

   AST_PAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~en_n) <= 1); // R7
   AST_PAD_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (~en_n != '0) |-> (valid && rw && !test_eff)); // R7
endmodule

// File: rtl/cpu_bus_decoder.sv
module cpu_bus_decoder
   import cbd_pkg::*;
#(
   parameter int RAM_AW       = 11,
   parameter int GFX_AW       = 3,
   parameter int OUT_W        = 3,
   parameter bit HAS_TEST_PIN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              rw,
   input  logic [15:0]       addr,
   input  logic [OUT_W-1:0]  bus_wdata,
   input  logic              test_mode,
   output logic              ram_sel,
   output logic [RAM_AW-1:0] ram_ofs,
   output logic              gfx_sel,
   output logic [GFX_AW-1:0] gfx_ofs,
   output logic              snd_sel,
   output logic              cart_sel,
   output logic              diag_sel,
   output logic [1:0]        diag_ofs,
   output logic              open_bus,
   output logic [OUT_W-1:0]  out_pins,
   output logic [1:0]        pad_en_n
);
   localparam int RAM_WIN_AW = 13;
   localparam int GFX_WIN_AW = 13;

   initial begin
      if (RAM_AW < 1 || RAM_AW > RAM_WIN_AW)
         $error("RAM_AW must lie in 1..%0d", RAM_WIN_AW);
      if (GFX_AW < 1 || GFX_AW > GFX_WIN_AW)
         $error("GFX_AW must lie in 1..%0d", GFX_WIN_AW);
      if (OUT_W < 1 || OUT_W > 8)
         $error("OUT_W must lie in 1..8");
   end

   logic    test_eff;
   region_e region;
   logic    strobe_wr;

   assign test_eff = HAS_TEST_PIN ? test_mode : 1'b0;

   cbd_region_decode u_region (
      .valid    (bus_valid),
      .rw       (rw),
      .addr     (addr),
      .test_eff (test_eff),
      .region   (region)
   );

   assign ram_sel  = (region == RG_RAM);
   assign gfx_sel  = (region == RG_GFX);
   assign snd_sel  = (region == RG_SND);
   assign cart_sel = (region == RG_CART);
   assign diag_sel = (region == RG_DIAG);
   assign open_bus = (region == RG_OPEN);

   assign ram_ofs  = addr[RAM_AW-1:0];
   assign gfx_ofs  = addr[GFX_AW-1:0];
   assign diag_ofs = addr[1:0];

   assign strobe_wr = bus_valid && !rw && (addr == PAD_BASE);

   cbd_out_latch #(.OUT_W(OUT_W)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (strobe_wr),
      .d     (bus_wdata),
      .q     (out_pins)
   );

   cbd_pad_enable #(.PADS(PAD_CNT)) u_pads (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (bus_valid),
      .rw       (rw),
      .test_eff (test_eff),
      .addr     (addr),
      .en_n     (pad_en_n)
   );

   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_sel, gfx_sel, snd_sel, cart_sel, diag_sel, open_bus})); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_valid |-> !(ram_sel || gfx_sel || snd_sel || cart_sel || diag_sel || open_bus)); // R5
   AST_OPEN_NO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      open_bus |-> (pad_en_n == 2'b11)); // R8
   AST_OPEN_TEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      open_bus |-> (test_mode && rw)); // R9
   AST_DIAG_TEST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      diag_sel |-> test_mode); // R8
endmodule

// File: tb/cpu_bus_decoder_tb_top.sv
`timescale 1ns/1ps
module cpu_bus_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        rw = 1'b1;
   logic [15:0] addr = 16'h0;
   logic [2:0]  bus_wdata = 3'h0;
   logic        test_mode = 1'b0;
   logic        ram_sel, gfx_sel, snd_sel, cart_sel, diag_sel, open_bus;
   logic [10:0] ram_ofs;
   logic [2:0]  gfx_ofs;
   logic [1:0]  diag_ofs;
   logic [2:0]  out_pins;
   logic [1:0]  pad_en_n;

   int checks = 0;
   int errors = 0;
   int exp_out = 0;

   always #2.5 clk = ~clk;

   cpu_bus_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .rw(rw), .addr(addr),
      .bus_wdata(bus_wdata), .test_mode(test_mode),
      .ram_sel(ram_sel), .ram_ofs(ram_ofs), .gfx_sel(gfx_sel), .gfx_ofs(gfx_ofs),
      .snd_sel(snd_sel), .cart_sel(cart_sel), .diag_sel(diag_sel),
      .diag_ofs(diag_ofs), .open_bus(open_bus), .out_pins(out_pins),
      .pad_en_n(pad_en_n)
   );

   // Reference model of the strobe latch
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) exp_out <= 0;
      else if (bus_valid && !rw && addr == 16'h4016) exp_out <= int'(bus_wdata);
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int a;
      int e_ram, e_gfx, e_snd, e_cart, e_diag, e_open, e_en0, e_en1;
      bit is_pad;
      a = int'(addr);
      is_pad = (a == 'h4016) || (a == 'h4017);
      e_ram = 0; e_gfx = 0; e_snd = 0; e_cart = 0; e_diag = 0; e_open = 0;
      e_en0 = 1; e_en1 = 1;
      if (bus_valid) begin
         if (a < 'h2000)                         e_ram = 1;
         else if (a < 'h4000)                    e_gfx = 1;
         else if (a < 'h4018) begin
            if (test_mode && rw && is_pad)       e_open = 1;
            else                                 e_snd = 1;
         end
         else if (test_mode && a <= 'h401A)      e_diag = 1;
         else                                    e_cart = 1;
         if (rw && !test_mode && a == 'h4016)    e_en0 = 0;
         if (rw && !test_mode && a == 'h4017)    e_en1 = 0;
      end
      check(int'(ram_sel) == e_ram, "R1", "ram_sel", int'(ram_sel), e_ram);
      if (e_ram == 1)
         check(int'(ram_ofs) == a % 2048, "R1", "ram_ofs", int'(ram_ofs), a % 2048);
      check(int'(gfx_sel) == e_gfx, "R2", "gfx_sel", int'(gfx_sel), e_gfx);
      if (e_gfx == 1)
         check(int'(gfx_ofs) == a % 8, "R2", "gfx_ofs", int'(gfx_ofs), a % 8);
      check(int'(snd_sel) == e_snd, "R3", "snd_sel", int'(snd_sel), e_snd);
      check(int'(cart_sel) == e_cart, "R4", "cart_sel", int'(cart_sel), e_cart);
      check(int'(diag_sel) == e_diag, "R8", "diag_sel", int'(diag_sel), e_diag);
      if (e_diag == 1)
         check(int'(diag_ofs) == a - 'h4018, "R8", "diag_ofs", int'(diag_ofs), a - 'h4018);
      check(int'(open_bus) == e_open, "R9", "open_bus", int'(open_bus), e_open);
      check($countones({ram_sel, gfx_sel, snd_sel, cart_sel, diag_sel, open_bus})
            == e_ram + e_gfx + e_snd + e_cart + e_diag + e_open, "R5", "select count",
            $countones({ram_sel, gfx_sel, snd_sel, cart_sel, diag_sel, open_bus}),
            e_ram + e_gfx + e_snd + e_cart + e_diag + e_open);
      check(int'(pad_en_n[0]) == e_en0, "R7", "pad_en_n[0]", int'(pad_en_n[0]), e_en0);
      check(int'(pad_en_n[1]) == e_en1, "R7", "pad_en_n[1]", int'(pad_en_n[1]), e_en1);
      check(int'(out_pins) == exp_out, "R6", "out_pins", int'(out_pins), exp_out);
   endtask

   // Drive one cycle at the falling edge, compare at the next falling edge
   task automatic cyc(input bit v, input bit r, input int a, input int d, input bit t);
      bus_valid = v; rw = r; addr = 16'(a); bus_wdata = 3'(d); test_mode = t;
      #1;
      compare_all();
      @(negedge clk);
      compare_all();
   endtask

   int edges[18] = '{'h0000, 'h07FF, 'h0800, 'h1FFF, 'h2000, 'h2007, 'h2008,
                     'h3FFF, 'h4000, 'h4015, 'h4016, 'h4017, 'h4018, 'h4019,
                     'h401A, 'h401B, 'h8000, 'hFFFF};

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_pins == 3'b000, "R6", "out_pins in reset", int'(out_pins), 0);
      check(pad_en_n == 2'b11, "R7", "pad_en_n idle", int'(pad_en_n), 3);
      rst_n = 1'b1;
      @(negedge clk);
      // R5: idle bus across all regions
      foreach (edges[i]) cyc(1'b0, 1'b1, edges[i], 7, 1'b0);
      // R1 R2 R3 R4 R7 R8 R9: every edge, both directions, both test settings
      for (int t = 0; t < 2; t++)
         for (int r = 0; r < 2; r++)
            foreach (edges[i]) cyc(1'b1, r[0], edges[i], i, t[0]);
      // R6: strobe writes, then non-strobe writes must not disturb pins
      cyc(1'b1, 1'b0, 'h4016, 5, 1'b0);
      cyc(1'b1, 1'b0, 'h4017, 2, 1'b0);
      cyc(1'b1, 1'b1, 'h4016, 0, 1'b0);
      cyc(1'b0, 1'b0, 'h4016, 3, 1'b0);
      cyc(1'b1, 1'b0, 'h4016, 6, 1'b1);
      cyc(1'b1, 1'b0, 'h0016, 1, 1'b0);
      cyc(1'b1, 1'b0, 'h4016, 1, 1'b0);
      cyc(1'b1, 1'b1, 'h0000, 0, 1'b0);
      // Random traffic, biased toward the I/O window
      for (int n = 0; n < 4000; n++) begin
         int a;
         a = ($urandom % 4 == 0) ? ('h4010 + $urandom % 16) : int'($urandom % 65536);
         cyc(1'($urandom % 8 != 0), 1'($urandom % 2), a, int'($urandom % 8),
             1'($urandom % 2));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule